// File: doc/BRIEF.md
# Montgomery Modular Exponentiation Engine

This block raises a base to an exponent modulo an odd modulus, all of them NBITS wide, and never divides by the modulus. Two Montgomery multiplier units work side by side. The squaring unit keeps the running power of the base. The multiplying unit folds that power into the accumulated result whenever the current exponent bit is set. Exponent bits are consumed from the least significant end. Each unit takes its first operand one bit per cycle and holds its second operand in parallel. Its accumulator stays in carry-save form, so the per-bit update is a row of full-adder cells fed by a four-way addend selector.

Software loads the base, exponent, modulus and the Montgomery constant R² mod N on parallel ports, where R = 2^(NBITS+2). It then pulses start and waits for the done pulse. A pre-conversion pass maps the base into Montgomery form and forms R mod N as the initial accumulator, with both units running at once. NBITS exponent steps follow. A post-conversion product with 1 and a single conditional subtraction of N return an ordinary residue.

Top module: `mexp_engine`

## Requirements
- R1: For odd mod_i ≥ 3, base_i < mod_i and r2_i = 2^(2·(NBITS+2)) mod mod_i, result_o equals base_i^exp_i mod mod_i once done_o pulses.
- R2: An exponent of zero yields 1, for any base below the modulus, including a base of 0.
- R3: Whenever done_o is high, result_o is strictly below the modulus captured at start.
- R4: done_o is high for exactly one cycle, (NBITS+2)·(NBITS+3) rising edges after the edge that sampled start_i. busy_o is high at every edge in between and low once done_o is high.
- R5: A start_i pulse while busy_o is high is ignored. Changing base_i, exp_i, mod_i and r2_i during a run does not alter the result or the latency.
- R6: After synchronous reset, busy_o and done_o are 0 and result_o is 0.
- R7: In each exponent step the squaring unit and the multiplying unit run concurrently. Each Montgomery product takes NBITS+3 cycles, so the exponent loop costs NBITS·(NBITS+3) cycles.
- R8: The latency is the same for every exponent. An all-ones exponent, which uses the multiplier in every step, still returns the correct residue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin an exponentiation; sampled only while idle |
| base_i | input | NBITS | Base, below the modulus |
| exp_i | input | NBITS | Exponent |
| mod_i | input | NBITS | Odd modulus |
| r2_i | input | NBITS | R² mod modulus, with R = 2^(NBITS+2) |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse when result_o is valid |
| result_o | output | NBITS | Exponentiation result, held until the next run |

## Verification
The bench targets the bounds of the lazy reduction:
- A base of N−1 and moduli close to 2^NBITS push the intermediate values toward 2N. A multiplier with too few serial steps or too narrow an accumulator would then wrap and return garbage.
- A post-conversion result equal to N checks the final subtraction. Without it, the engine would hand back N instead of 0.
- Exponents 0, 1 and all-ones cover the cases where the multiplier never runs, runs once, and runs in every step. A wrong initial accumulator (anything but R mod N) or a multiplier fed the already-updated power would show up in these cases.
- A stray start pulse with different operands in mid-run checks that the operands captured at start are kept.

// File: rtl/mexp_pkg.sv
`timescale 1ns/1ps
package mexp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRE  = 2'd1,
        ST_LOOP = 2'd2,
        ST_POST = 2'd3
    } mexp_state_e;

    typedef enum logic [1:0] {
        ADD_NONE = 2'd0,
        ADD_B    = 2'd1,
        ADD_N    = 2'd2,
        ADD_BN   = 2'd3
    } mexp_addsel_e;

    // serial steps of one Montgomery product for an nb-bit modulus (R = 2^(nb+2))
    function automatic int unsigned mont_steps(input int unsigned nb);
        return nb + 2;
    endfunction

    // cycles from the start edge to the done edge
    function automatic int unsigned exp_latency(input int unsigned nb);
        return (nb + 2) * (nb + 3);
    endfunction

endpackage

// File: rtl/mexp_csa_cell.sv
`timescale 1ns/1ps
module mexp_csa_cell (
    input  logic x_i,
    input  logic y_i,
    input  logic z_i,
    output logic s_o,
    output logic c_o
);
    assign s_o = x_i ^ y_i ^ z_i;
    assign c_o = (x_i & y_i) | (x_i & z_i) | (y_i & z_i);
endmodule

// File: rtl/mexp_mont_unit.sv
`timescale 1ns/1ps
module mexp_mont_unit
    import mexp_pkg::*;
#(
    parameter int unsigned NBITS = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [NBITS:0]   a_i,
    input  logic [NBITS:0]   b_i,
    input  logic [NBITS-1:0] mod_i,
    output logic             done_o,
    output logic [NBITS:0]   res_o
);
    localparam int unsigned STEPS = mont_steps(NBITS);
    localparam int unsigned ACCW  = NBITS + 3;
    localparam int unsigned CW    = $clog2(STEPS + 1);

    logic [STEPS-1:0] a_sh;
    logic [ACCW-1:0]  b_q, n_q, bn_q;
    logic [ACCW-1:0]  s_q, c_q;
    logic [CW-1:0]    cnt;
    logic             run;

    logic             a_bit, qbit;
    mexp_addsel_e     sel;
    logic [ACCW-1:0]  addend;
    logic [ACCW-1:0]  sum_w, cry_w;
    logic [ACCW-1:0]  s_d;

    assign a_bit = a_sh[0];
    // quotient bit that makes the low bit of the new accumulator zero (N is odd)
    assign qbit  = s_q[0] ^ c_q[0] ^ (a_bit & b_q[0]);
    assign sel   = mexp_addsel_e'({qbit, a_bit});

    always_comb begin
        case (sel)
            ADD_B:   addend = b_q;
            ADD_N:   addend = n_q;
            ADD_BN:  addend = bn_q;
            default: addend = '0;
        endcase
    end

    for (genvar i = 0; i < ACCW; i++) begin : g_row
        mexp_csa_cell u_cell (
            .x_i (s_q[i]),
            .y_i (c_q[i]),
            .z_i (addend[i]),
            .s_o (sum_w[i]),
            .c_o (cry_w[i])
        );
    end

    // halving: sum bits drop their zero LSB, carry bits lose their implied shift
    assign s_d = sum_w >> 1;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_sh   <= '0;
            b_q    <= '0;
            n_q    <= '0;
            bn_q   <= '0;
            s_q    <= '0;
            c_q    <= '0;
            cnt    <= '0;
            run    <= 1'b0;
            done_o <= 1'b0;
        end else if (start_i) begin
            a_sh   <= STEPS'(a_i);
            b_q    <= ACCW'(b_i);
            n_q    <= ACCW'(mod_i);
            bn_q   <= ACCW'(b_i) + ACCW'(mod_i);
            s_q    <= '0;
            c_q    <= '0;
            cnt    <= '0;
            run    <= 1'b1;
            done_o <= 1'b0;
        end else if (run) begin
            a_sh   <= a_sh >> 1;
            s_q    <= s_d;
            c_q    <= cry_w;
            cnt    <= cnt + 1'b1;
            if (cnt == CW'(STEPS - 1)) begin
                run    <= 1'b0;
                done_o <= 1'b1;
            end else begin
                done_o <= 1'b0;
            end
        end else begin
            done_o <= 1'b0;
        end
    end

    // the true value stays below 2N, so the low NBITS+1 bits hold it exactly
    assign res_o = s_q[NBITS:0] + c_q[NBITS:0];

endmodule

// File: rtl/mexp_engine.sv
`timescale 1ns/1ps
module mexp_engine
    import mexp_pkg::*;
#(
    parameter int unsigned NBITS = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [NBITS-1:0] base_i,
    input  logic [NBITS-1:0] exp_i,
    input  logic [NBITS-1:0] mod_i,
    input  logic [NBITS-1:0] r2_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [NBITS-1:0] result_o
);
    localparam int unsigned BCW = $clog2(NBITS + 1);
    localparam logic [NBITS:0] ONE = (NBITS + 1)'(1);

    mexp_state_e      state;
    logic [NBITS-1:0] n_q;
    logic [NBITS-1:0] e_sh;
    logic [BCW-1:0]   bit_cnt;
    logic [NBITS-1:0] res_q;
    logic             done_q;

    logic             sq_start, mul_start, sq_done, mul_done;
    logic [NBITS:0]   sq_a, sq_b, mul_a, mul_b;
    logic [NBITS:0]   p_val, a_val;
    logic [NBITS-1:0] mod_sel;
    logic             last_bit, step_go, in_loop;
    logic             res_ge;
    logic [NBITS-1:0] res_final;

    assign in_loop  = (state == ST_LOOP);
    assign last_bit = (bit_cnt == BCW'(NBITS - 1));
    // a new exponent step is launched when the previous product pair is complete
    assign step_go  = sq_done && ((state == ST_PRE) || (in_loop && !last_bit));
    assign mod_sel  = (state == ST_IDLE) ? mod_i : n_q;

    always_comb begin
        sq_a  = p_val;
        sq_b  = p_val;
        mul_a = a_val;
        mul_b = p_val;
        if (state == ST_IDLE) begin
            sq_a  = {1'b0, base_i};
            sq_b  = {1'b0, r2_i};
            mul_a = {1'b0, r2_i};
            mul_b = ONE;
        end else if (in_loop && last_bit) begin
            mul_b = ONE;
        end
    end

    assign sq_start  = ((state == ST_IDLE) && start_i) || step_go;
    assign mul_start = ((state == ST_IDLE) && start_i)
                     || (step_go && e_sh[0])
                     || (in_loop && last_bit && sq_done);

    mexp_mont_unit #(.NBITS(NBITS)) u_sq (
        .clk     (clk),
        .rst     (rst),
        .start_i (sq_start),
        .a_i     (sq_a),
        .b_i     (sq_b),
        .mod_i   (mod_sel),
        .done_o  (sq_done),
        .res_o   (p_val)
    );

    mexp_mont_unit #(.NBITS(NBITS)) u_mul (
        .clk     (clk),
        .rst     (rst),
        .start_i (mul_start),
        .a_i     (mul_a),
        .b_i     (mul_b),
        .mod_i   (mod_sel),
        .done_o  (mul_done),
        .res_o   (a_val)
    );

    assign res_ge    = (a_val >= {1'b0, n_q});
    assign res_final = res_ge ? (a_val[NBITS-1:0] - n_q) : a_val[NBITS-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            n_q     <= '0;
            e_sh    <= '0;
            bit_cnt <= '0;
            res_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        n_q     <= mod_i;
                        e_sh    <= exp_i;
                        bit_cnt <= '0;
                        state   <= ST_PRE;
                    end
                end
                ST_PRE: begin
                    if (sq_done) begin
                        e_sh    <= e_sh >> 1;
                        bit_cnt <= '0;
                        state   <= ST_LOOP;
                    end
                end
                ST_LOOP: begin
                    if (sq_done) begin
                        if (last_bit) begin
                            state <= ST_POST;
                        end else begin
                            e_sh    <= e_sh >> 1;
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
                default: begin
                    if (mul_done) begin
                        res_q  <= res_final;
                        done_q <= 1'b1;
                        state  <= ST_IDLE;
                    end
                end
            endcase
        end
    end

    assign busy_o   = (state != ST_IDLE);
    assign done_o   = done_q;
    assign result_o = res_q;

endmodule

// File: rtl/mexp_engine_chk.sv
`timescale 1ns/1ps
module mexp_engine_chk #(
    parameter int unsigned NBITS = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic             busy_o,
    input logic             done_o,
    input logic [NBITS-1:0] result_o,
    input logic [NBITS-1:0] mod_q,
    input logic             sq_done,
    input logic             mul_done,
    input logic             in_loop
);
    // R3
    result_range_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (result_o < mod_q));

    // R4
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R4
    busy_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(start_i));

    // R5
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i) |=> $stable(mod_q));

    // R7
    unit_lockstep_chk: assert property (@(posedge clk) disable iff (rst)
        (in_loop && mul_done) |-> sq_done);

endmodule

bind mexp_engine mexp_engine_chk #(.NBITS(NBITS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .result_o (result_o),
    .mod_q    (n_q),
    .sq_done  (sq_done),
    .mul_done (mul_done),
    .in_loop  (in_loop)
);

// File: tb/tb_mexp_engine.sv
`timescale 1ns/1ps
module tb_mexp_engine;
    localparam int NB  = 6;
    localparam int LAT = (NB + 2) * (NB + 3);
    localparam longint RSQ = longint'(1) << (2 * (NB + 2));

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic [NB-1:0] base_i = '0, exp_i = '0, mod_i = '0, r2_i = '0;
    logic          busy_o, done_o;
    logic [NB-1:0] result_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    mexp_engine #(.NBITS(NB)) dut (
        .clk(clk), .rst(rst), .start_i(start_i),
        .base_i(base_i), .exp_i(exp_i), .mod_i(mod_i), .r2_i(r2_i),
        .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
    );

    function automatic longint ref_pow(input longint m, input longint e, input longint n);
        longint acc = 1 % n;
        longint p = m % n;
        for (int i = 0; i < NB; i++) begin
            if ((e >> i) & 1) acc = (acc * p) % n;
            p = (p * p) % n;
        end
        return acc;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    // poke: issue a second start with other operands part way through the run
    task automatic run_exp(input int m, input int e, input int n, input bit poke);
        int k;
        bit busy_bad;
        longint expv;
        @(negedge clk);
        base_i  = NB'(m);
        exp_i   = NB'(e);
        mod_i   = NB'(n);
        r2_i    = NB'(RSQ % n);
        start_i = 1'b1;
        @(posedge clk);
        #1 start_i = 1'b0;
        k = 0;
        busy_bad = 1'b0;
        while (1) begin
            @(posedge clk);
            #1;
            k++;
            if (done_o) break;
            if (!busy_o) busy_bad = 1'b1;
            if (poke && k == 10) begin
                base_i  = NB'(m + 3);
                exp_i   = NB'(e ^ 5);
                mod_i   = NB'(9);
                r2_i    = NB'(RSQ % 9);
                start_i = 1'b1;
            end
            if (poke && k == 11) start_i = 1'b0;
            if (k > 4 * LAT) break;
        end
        expv = ref_pow(m, e, n);
        if (e == 0) check(result_o == NB'(expv), "R2", result_o, expv);
        else if (e == (1 << NB) - 1) check(result_o == NB'(expv), "R8", result_o, expv);
        else if (poke) check(result_o == NB'(expv), "R5", result_o, expv);
        else check(result_o == NB'(expv), "R1", result_o, expv);
        // R4 / R7: fixed latency, busy throughout, R3 range
        check(k == LAT, "R4/R7 latency", k, LAT);
        check(!busy_bad && !busy_o, "R4 busy", busy_bad, 0);
        check(result_o < NB'(n), "R3", result_o, n);
        @(posedge clk);
        #1;
        check(!done_o, "R4 pulse", done_o, 0);
    endtask

    initial begin
        #(20.0 * 200000);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R6
        check(!busy_o, "R6 busy", busy_o, 0);
        check(!done_o, "R6 done", done_o, 0);
        check(result_o == '0, "R6 result", result_o, 0);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check(!busy_o && !done_o, "R6 after release", busy_o, 0);

        for (int n = 3; n < (1 << NB); n += 2) begin
            for (int mi = 0; mi < 4; mi++) begin
                int m;
                case (mi)
                    0: m = 0;
                    1: m = 1;
                    2: m = n - 1;
                    default: m = (n * 5 + 7) % n;
                endcase
                run_exp(m, 0, n, 1'b0);
                run_exp(m, 1, n, 1'b0);
                run_exp(m, (1 << NB) - 1, n, 1'b0);
                run_exp(m, 2, n, 1'b0);
                run_exp(m, (n * 7 + mi * 11) & ((1 << NB) - 1), n, 1'b0);
            end
        end

        // R5: restart attempts mid-run must be ignored
        run_exp(5, 13, 23, 1'b1);
        run_exp(62, 47, 63, 1'b1);
        run_exp(2, 0, 61, 1'b1);

        finish_run();
    end
endmodule